// File: doc/BRIEF.md
# Two-Master Split-Aware Bus Arbiter

This block decides which of two bus masters drives a shared bus. Master 1 wins when both ask at once, and a master that holds the bus keeps it for as long as it holds its request. The address decoder tells each master whether its current target is the split-capable slave. That slave can answer a transfer with a split indication. The arbiter then takes the bus away from the owner and remembers it as the parked master. While one master is parked, the other master can use the bus, but only for slaves that never split.

When the split slave reports that it is ready, the arbiter records this. At the first point where the bus is free, it hands the bus back to the parked master. In that cycle it also drives a one-cycle split-grant pulse to the slave, so the slave can finish the pending transfer. All outputs are registered, and a change on the inputs shows up on the outputs one clock edge later.

Top module: `split_bus_arbiter`

## Requirements
- R1: At most one of `m1_grant` and `m2_grant` is high at any time. `owner_sel` reads 0 when master 1 holds the bus and 1 when master 2 does. It reads 0 when nobody holds the bus.
- R2: When the bus is free, no split is pending and both masters request, master 1 is granted at the next edge.
- R3: An owner that keeps its request high, with no split indication, keeps its grant. A request from the other master does not take the bus away. When the owner drops its request, the bus is re-arbitrated at that same edge.
- R4: If `bus_split` is high while a master owns the bus and no split is pending, that master loses its grant at the next edge and is parked. At the same edge the other master may be granted, if it is eligible.
- R5: While a split is pending, the non-parked master is not granted while its `mN_to_split` is 1. It is granted when its `mN_to_split` is 0.
- R6: A pulse on `split_ready` while a master is parked is latched at that edge. The parked master is granted at the first later edge at which the bus is free. This resume takes priority over any new request.
- R7: `split_grant` is high for exactly one cycle: the first cycle in which the resumed master's grant is high.
- R8: `split_ready` has no effect when no master is parked. A master parked afterwards is not resumed by that earlier pulse.
- R9: With no request, no parked master and no latched ready, no grant is asserted.
- R10: Driving `rst_n` low clears the grants at once, without waiting for a clock edge. It also discards any parked master and any latched ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m1_req | input | 1 | Master 1 requests the bus |
| m1_to_split | input | 1 | Master 1's current target is the split-capable slave |
| m2_req | input | 1 | Master 2 requests the bus |
| m2_to_split | input | 1 | Master 2's current target is the split-capable slave |
| bus_split | input | 1 | The slave being accessed answers with split |
| split_ready | input | 1 | The split slave can now complete the parked transfer |
| m1_grant | output | 1 | Master 1 owns the bus |
| m2_grant | output | 1 | Master 2 owns the bus |
| owner_sel | output | 1 | Current owner: 0 = master 1, 1 = master 2 |
| split_grant | output | 1 | One-cycle pulse when the bus returns to the parked master |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a split and a handover. The bench raises `bus_split` on master 1 while master 2 is already requesting a non-split slave. It expects master 1 parked and master 2 granted at that one edge. It then repeats the case with master 2 parked and master 1 aiming at the split slave, and expects nobody granted.

The second pair is a ready and a resume. The bench pulses `split_ready` while the other master still owns the bus, and also while a new request is waiting. It judges that the resume waits for a free bus, then beats the new request, and that the one-cycle `split_grant` pulse lines up with it.

// File: rtl/sba_pkg.sv
// Package: sba_pkg
// Shared constants and types for the split-aware two-master arbiter.
// Assumes master index 0 is master 1 (highest priority) and index 1 is master 2.
package sba_pkg;
    localparam int NUM_MASTERS = 2;
    localparam int ID_W        = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

    typedef logic [ID_W-1:0] mid_t;

    // A slot names one master, or none when vld is low.
    typedef struct packed {
        logic vld;
        mid_t id;
    } slot_t;
endpackage

// File: rtl/sba_pick.sv
// Module: sba_pick
// Combinational next-owner selection. The current owner keeps the bus while
// it holds its request and no split occurs. Otherwise a latched resume of the
// parked master wins. Otherwise the lowest-index eligible requester wins.
// Assumes bus_split is only meaningful while an owner exists and nothing is
// already parked.
module sba_pick
    import sba_pkg::*;
(
    input  slot_t                  owner,
    input  slot_t                  parked,
    input  logic                   ready_q,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic [NUM_MASTERS-1:0] to_split,
    input  logic                   bus_split,
    output slot_t                  nxt_owner,
    output logic                   resume,
    output logic                   park_new
);
    logic                   keep;
    logic                   pend_after;
    mid_t                   park_id_after;
    logic [NUM_MASTERS-1:0] elig;

    // Split takes effect only on a live owner with nothing parked.
    assign park_new      = owner.vld && bus_split && !parked.vld;
    assign keep          = owner.vld && req[owner.id] && !park_new;
    assign pend_after    = parked.vld || park_new;
    assign park_id_after = parked.vld ? parked.id : owner.id;

    // Per-master eligibility: requesting, not parked, not aimed at a busy split slave.
    for (genvar gm = 0; gm < NUM_MASTERS; gm++) begin : g_elig
        assign elig[gm] = req[gm]
                       && !(pend_after && (park_id_after == mid_t'(gm)))
                       && !(pend_after && to_split[gm]);
    end

    // Choose the next owner: keep, else resume, else fixed priority.
    always_comb begin
        nxt_owner = '0;
        resume    = 1'b0;
        if (keep) begin
            nxt_owner = owner;
        end else if (parked.vld && ready_q) begin
            nxt_owner.vld = 1'b1;
            nxt_owner.id  = parked.id;
            resume        = 1'b1;
        end else begin
            for (int m = NUM_MASTERS - 1; m >= 0; m--) begin
                if (elig[m]) begin
                    nxt_owner.vld = 1'b1;
                    nxt_owner.id  = mid_t'(m);
                end
            end
        end
    end
endmodule

// File: rtl/sba_park.sv
// Module: sba_park
// Holds the parked master and the latched readiness of the split slave.
// Assumes park_new and resume are never high in the same cycle (resume
// needs an existing park, park_new needs none).
module sba_park
    import sba_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  park_new,
    input  mid_t  owner_id,
    input  logic  resume,
    input  logic  split_ready,
    output slot_t parked,
    output logic  ready_q
);
    // Record, clear and arm the parked master.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            parked  <= '0;
            ready_q <= 1'b0;
        end else if (park_new) begin
            parked.vld <= 1'b1;
            parked.id  <= owner_id;
            ready_q    <= 1'b0;
        end else if (resume) begin
            parked  <= '0;
            ready_q <= 1'b0;
        end else if (parked.vld && split_ready) begin
            ready_q <= 1'b1;
        end
    end

    // A latched ready always belongs to a parked master.
    assert_ready_has_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |-> parked.vld);
endmodule

// File: rtl/sba_owner.sv
// Module: sba_owner
// Registers the bus owner and the resume pulse, and decodes the per-master
// grants and the owner select. Assumes nxt_owner comes from sba_pick.
module sba_owner
    import sba_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  slot_t                  nxt_owner,
    input  logic                   resume,
    output slot_t                  owner,
    output logic [NUM_MASTERS-1:0] grant,
    output mid_t                   owner_sel,
    output logic                   split_grant
);
    // Owner register and split-grant pulse register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner       <= '0;
            split_grant <= 1'b0;
        end else begin
            owner       <= nxt_owner;
            split_grant <= resume;
        end
    end

    // One grant line per master.
    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_grant
        assign grant[g] = owner.vld && (owner.id == mid_t'(g));
    end

    assign owner_sel = owner.vld ? owner.id : '0;

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        split_grant |=> !split_grant);
endmodule

// File: rtl/split_bus_arbiter.sv
// Module: split_bus_arbiter
// Fixed-priority arbiter for two masters with split-transaction parking.
// Master 1 has the higher priority. A split parks the owner. The other master
// may then use non-split slaves until the split slave reports ready. After
// that the parked master is resumed with a one-cycle split_grant pulse.
// Assumes the address decoder supplies mN_to_split for each master's target.
module split_bus_arbiter
    import sba_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic m1_req,
    input  logic m1_to_split,
    input  logic m2_req,
    input  logic m2_to_split,
    input  logic bus_split,
    input  logic split_ready,
    output logic m1_grant,
    output logic m2_grant,
    output logic owner_sel,
    output logic split_grant
);
    slot_t                  owner;
    slot_t                  parked;
    slot_t                  nxt_owner;
    logic                   ready_q;
    logic                   resume;
    logic                   park_new;
    logic [NUM_MASTERS-1:0] grant;
    mid_t                   sel;

    sba_pick u_pick (
        .owner     (owner),
        .parked    (parked),
        .ready_q   (ready_q),
        .req       ({m2_req, m1_req}),
        .to_split  ({m2_to_split, m1_to_split}),
        .bus_split (bus_split),
        .nxt_owner (nxt_owner),
        .resume    (resume),
        .park_new  (park_new)
    );

    sba_park u_park (
        .clk         (clk),
        .rst_n       (rst_n),
        .park_new    (park_new),
        .owner_id    (owner.id),
        .resume      (resume),
        .split_ready (split_ready),
        .parked      (parked),
        .ready_q     (ready_q)
    );

    sba_owner u_owner (
        .clk         (clk),
        .rst_n       (rst_n),
        .nxt_owner   (nxt_owner),
        .resume      (resume),
        .owner       (owner),
        .grant       (grant),
        .owner_sel   (sel),
        .split_grant (split_grant)
    );

    assign m1_grant  = grant[0];
    assign m2_grant  = grant[1];
    assign owner_sel = sel[0];

    assert_sel_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(m1_grant || m2_grant) |-> !owner_sel);
    assert_m1_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (m1_grant && m1_req && !bus_split) |=> m1_grant);
    assert_m2_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (m2_grant && m2_req && !bus_split) |=> m2_grant);
    assert_park_m1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m1_grant && bus_split && !parked.vld) |=> (!m1_grant && parked.vld));
    assert_holdoff_m1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(m1_grant) && parked.vld && parked.id == mid_t'(1)) |-> !$past(m1_to_split));
    assert_holdoff_m2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(m2_grant) && parked.vld && parked.id == mid_t'(0)) |-> !$past(m2_to_split));
    assert_pulse_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        split_grant |-> ($rose(m1_grant) || $rose(m2_grant)));
    assert_idle_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!m1_req && !m2_req && !parked.vld) |=> !(m1_grant || m2_grant));
endmodule

// File: tb/tb_split_bus_arbiter.sv
module tb_split_bus_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m1_req = 0, m1_to_split = 0, m2_req = 0, m2_to_split = 0;
    logic bus_split = 0, split_ready = 0;
    logic m1_grant, m2_grant, owner_sel, split_grant;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        logic  g1;
        logic  g2;
        logic  sel;
        logic  sg;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    split_bus_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .m1_req(m1_req), .m1_to_split(m1_to_split),
        .m2_req(m2_req), .m2_to_split(m2_to_split),
        .bus_split(bus_split), .split_ready(split_ready),
        .m1_grant(m1_grant), .m2_grant(m2_grant),
        .owner_sel(owner_sel), .split_grant(split_grant)
    );

    task automatic check_now(input logic g1, input logic g2, input logic sel,
                             input logic sg, input string tag);
        n_checks++;
        if ({m1_grant, m2_grant, owner_sel, split_grant} !== {g1, g2, sel, sg}) begin
            n_fail++;
            $display("FAIL %s: got g1=%b g2=%b sel=%b sg=%b, expected g1=%b g2=%b sel=%b sg=%b",
                     tag, m1_grant, m2_grant, owner_sel, split_grant, g1, g2, sel, sg);
        end
    endtask

    // Monitor: pops one expected item per falling edge and compares.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check_now(e.g1, e.g2, e.sel, e.sg, e.tag);
        end
    end

    // Driver: applies one cycle of inputs and queues the expected outputs after the edge.
    task automatic step(input logic r1, input logic s1, input logic r2, input logic s2,
                        input logic bs, input logic sr,
                        input logic g1, input logic g2, input logic sel, input logic sg,
                        input string tag);
        exp_t e;
        m1_req = r1; m1_to_split = s1; m2_req = r2; m2_to_split = s2;
        bus_split = bs; split_ready = sr;
        @(posedge clk);
        #1;
        e.g1 = g1; e.g2 = g2; e.sel = sel; e.sg = sg; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_now(0, 0, 0, 0, "R10 grants low in reset");
        rst_n = 1'b1;

        // Basic ownership and priority
        step(0,0,0,0,0,0, 0,0,0,0, "R9 idle");
        step(0,0,1,0,0,0, 0,1,1,0, "R1 m2 alone, sel=1");
        step(1,0,1,0,0,0, 0,1,1,0, "R3 no preemption by m1");
        step(1,0,0,0,0,0, 1,0,0,0, "R3 handover on release");
        step(0,0,0,0,0,0, 0,0,0,0, "R9 idle again");
        step(1,0,1,0,0,0, 1,0,0,0, "R2 m1 wins tie");
        step(0,0,1,0,0,0, 0,1,1,0, "R3 m2 after m1 release");
        step(0,0,0,0,0,0, 0,0,0,0, "R9 idle");

        // Split on m1, m2 takes the bus at the same edge
        step(1,1,0,0,0,0, 1,0,0,0, "R2 m1 to split slave");
        step(1,1,1,0,1,0, 0,1,1,0, "R4 m1 parked, m2 granted same edge");
        step(1,1,1,0,0,0, 0,1,1,0, "R5 m2 on non-split slave keeps bus");
        step(1,1,1,0,0,1, 0,1,1,0, "R6 ready while m2 owns, no preempt");
        step(1,1,0,0,0,0, 1,0,0,1, "R7 resume m1 with pulse");
        step(1,1,0,0,0,0, 1,0,0,0, "R7 pulse lasts one cycle");
        step(0,0,0,0,0,0, 0,0,0,0, "R9 idle after split");

        // Split on m2, m1 held off from split slave
        step(0,0,1,1,0,0, 0,1,1,0, "R1 m2 to split slave");
        step(1,1,1,1,1,0, 0,0,0,0, "R5 m1 to split slave held off");
        step(1,1,1,1,0,0, 0,0,0,0, "R5 still held off");
        step(1,0,1,1,0,0, 1,0,0,0, "R5 m1 non-split granted");
        step(0,0,1,1,0,1, 0,0,0,0, "R6 ready latched, not yet resumed");
        step(1,0,1,1,0,0, 0,1,1,1, "R6 resume beats m1 request");
        step(1,0,0,0,0,0, 1,0,0,0, "R3 m1 after resumed m2");
        step(0,0,0,0,0,0, 0,0,0,0, "R9 idle");

        // Ready with nothing parked is ignored
        step(0,0,0,0,0,1, 0,0,0,0, "R8 ready with no park");
        step(0,0,1,1,0,0, 0,1,1,0, "R8 m2 granted");
        step(0,0,1,1,1,0, 0,0,0,0, "R4 m2 parked alone");
        step(0,0,1,1,0,0, 0,0,0,0, "R8 earlier ready not applied");
        step(0,0,1,1,0,0, 0,0,0,0, "R8 still waiting");
        step(0,0,1,1,0,1, 0,0,0,0, "R6 ready latched");
        step(0,0,1,1,0,0, 0,1,1,1, "R7 resume m2 with pulse");
        step(0,0,0,0,0,0, 0,0,0,0, "R9 idle");

        // Asynchronous reset clears grant and park
        step(1,1,0,0,0,0, 1,0,0,0, "R10 setup m1 owner");
        step(1,1,0,0,1,0, 0,0,0,0, "R10 setup m1 parked");
        step(0,0,1,0,0,0, 0,1,1,0, "R10 setup m2 owner");
        #2 rst_n = 1'b0;
        #1 check_now(0, 0, 0, 0, "R10 async clear of grant");
        m1_req = 0; m2_req = 0;
        @(negedge clk);
        rst_n = 1'b1;
        step(0,0,0,0,0,1, 0,0,0,0, "R10 park discarded, ready ignored");
        step(0,0,0,0,0,0, 0,0,0,0, "R10 no resume after reset");

        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule